// File: doc/BRIEF.md
# Graphic LCD Display RAM Host Interface

This block is the host-facing half of a dot-matrix LCD column driver. A host on an 8-bit parallel bus issues instruction and data cycles. Instructions set a page counter (X) and a line counter (Y), pick which of the two counters steps after each data access and in which direction, set the display start line, switch the display on or off, and read a status byte. Data cycles write or read one byte of the display memory at the current (X, Y) position. That memory holds 64 display lines plus one flag line, with 10 byte-wide pages per line.

Every accepted instruction or data cycle other than a status read makes the block busy. The busy flag clears on the second rising edge of the slow scan clock `phi`, counted after `phi` has passed through a two-flop synchronizer. While busy, only status reads are honoured. The start line and on/off state are driven out for the scan logic, which is not part of this block.

The bus is sampled on `clk`. A cycle with `ce_n` low is one access. `di` high marks a data access and `di` low an instruction. `wr_n` low marks a write and `wr_n` high a read. Read results appear on `dout` in the cycle after the access and stay there until the next honoured read.

Top module: `glcd_host_if`

## Requirements
- R1: On a clock edge with `rst_n` low, the following are cleared: X, Y, the busy flag, the display on/off bit and the start line. The mode becomes X-counter/up, and `dout` reads 0x00 from the next cycle.
- R2: A data write (`di`=1, `wr_n`=0) stores `din` at page X, line Y. A data read (`di`=1, `wr_n`=1) puts the byte stored at (X, Y) on `dout` in the next cycle.
- R3: After every honoured data read or write, the selected counter steps by one. X wraps between 9 and 0, and Y wraps between 64 and 0, in both directions.
- R4: Instruction 0001_00SD selects the counter and direction. S=1 selects Y and S=0 selects X. D=1 counts down and D=0 counts up.
- R5: Instruction 0010_xxxx loads X with xxxx, and 1yyy_yyyy loads Y with yyyyyyy. A value above 9 for X, or above 64 for Y, leaves that counter unchanged.
- R6: Instruction 01ss_ssss loads the 6-bit start line, which appears on `start_line` in the next cycle.
- R7: Instruction 0000_001o sets the display on/off bit to o, visible on `disp_on`. Changing it never alters the display memory.
- R8: A status read (`di`=0, `wr_n`=1) puts {busy, 0, on/off, 00000} on `dout` in the next cycle. It does not set busy and is honoured while busy.
- R9: Every honoured access other than a status read sets busy. Busy clears on the second synchronized `phi` rising edge after the access, so it lasts between one and two `phi` periods plus the synchronizer delay.
- R10: While busy, every access other than a status read is ignored. Registers, counters, memory and `dout` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus sampling happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phi | input | 1 | Slow scan clock, asynchronous to `clk`, times the busy interval |
| ce_n | input | 1 | Access strobe, active low, one access per cycle it is low |
| wr_n | input | 1 | Low for write, high for read |
| di | input | 1 | High for data access, low for instruction/status |
| din | input | 8 | Instruction or write data byte |
| dout | output | 8 | Status byte or read data, held until the next honoured read |
| disp_on | output | 1 | Display on/off state for the scan side |
| start_line | output | 6 | Display start line for the scan side |

## Verification
Several properties are checked on every cycle. The reset values are checked. Any honoured non-status access must raise busy, and once raised, busy must survive at least one more cycle. The status byte must mirror the previous cycle's busy and on/off state. While busy, the on/off and start-line registers must not move. The X up-step with its wrap is also checked on every cycle. The bench scenarios are needed for the rest. They cover the memory contents after chains of writes in all four counting modes, wrapping at both ends of each counter, rejected out-of-range address loads, and the total length of the busy window. They also show that a data write or read issued while busy leaves both the memory and `dout` untouched.

// File: rtl/glcd_pkg.sv
// Package: shared definitions for the graphic LCD host interface.
// Assumes instructions are always one byte wide.
package glcd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_SET_X,
        OP_SET_Y,
        OP_START,
        OP_MODE,
        OP_DISP
    } glcd_op_e;

    // Classify an instruction byte by its leading prefix bits.
    function automatic glcd_op_e decode_op(input logic [BYTE_W-1:0] b);
        if (b[7])                     return OP_SET_Y;
        else if (b[6])                return OP_START;
        else if (b[5:4] == 2'b10)     return OP_SET_X;
        else if (b[5:2] == 4'b0100)   return OP_MODE;
        else if (b[5:1] == 5'b00001)  return OP_DISP;
        else                          return OP_NOP;
    endfunction

endpackage

// File: rtl/glcd_phi_sync.sv
// Module: brings the asynchronous phi clock into the clk domain and
// emits a one-cycle pulse per phi rising edge. Assumes phi is much
// slower than clk, so that no edge is lost.
module glcd_phi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi,
    output logic rise
);

    logic [STAGES:0] sh;

    // Shift phi through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], phi};
    end

    // Edge detect on the last synchronized stage.
    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/glcd_busy_timer.sv
// Module: busy flag raised by start and released on the EDGES-th tick
// after it. A tick arriving in the start cycle is not counted.
module glcd_busy_timer #(
    parameter int EDGES = 2,
    localparam int CW   = $clog2(EDGES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy
);

    logic [CW-1:0] cnt;

    // Arm on start, count ticks while busy, release on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy && tick) begin
            if (cnt == CW'(EDGES - 1)) busy <= 1'b0;
            else                       cnt  <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/glcd_wrap_ctr.sv
// Module: modulo-MODULUS up/down counter with a parallel load. Load has
// priority over step. Assumes load_val is already below MODULUS.
module glcd_wrap_ctr #(
    parameter int MODULUS = 10,
    localparam int W      = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    // Load, or step one position with wrap at either end.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load)    q <= load_val;
        else if (step) begin
            if (down) q <= (q == '0)  ? TOP : q - W'(1);
            else      q <= (q == TOP) ? '0  : q + W'(1);
        end
    end

endmodule

// File: rtl/glcd_disp_ram.sv
// Module: single-port display memory with a registered read. The contents
// are not reset; write and read may not target the same cycle.
module glcd_disp_ram #(
    parameter int DEPTH = 650,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write on we, register the addressed byte on re.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata     <= mem[addr];
    end

endmodule

// File: rtl/glcd_host_if.sv
// Module: host interface of the LCD column driver. It decodes bus accesses,
// keeps the X/Y address counters, the mode register, the on/off bit and the
// start line, and gates everything behind the busy flag. Assumes a
// synchronous bus sampled on clk, one access per cycle with ce_n low.
module glcd_host_if #(
    parameter int X_PAGES     = 10,
    parameter int Y_LINES     = 65,
    parameter int LINE_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_EDGES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       phi,
    input  logic                       ce_n,
    input  logic                       wr_n,
    input  logic                       di,
    input  logic [glcd_pkg::BYTE_W-1:0] din,
    output logic [glcd_pkg::BYTE_W-1:0] dout,
    output logic                       disp_on,
    output logic [LINE_W-1:0]          start_line
);
    import glcd_pkg::*;

    localparam int XW    = $clog2(X_PAGES);
    localparam int YW    = $clog2(Y_LINES);
    localparam int DEPTH = X_PAGES * Y_LINES;
    localparam int AW    = $clog2(DEPTH);

    logic            busy, phi_rise;
    logic            is_status, accept, data_acc, instr_wr;
    logic            mode_y, mode_down;
    logic [XW-1:0]   x_q;
    logic [YW-1:0]   y_q;
    logic [AW-1:0]   ram_addr;
    logic [BYTE_W-1:0] ram_q, status_q;
    logic            show_status;
    glcd_op_e        op;
    logic            ld_x, ld_y;

    // Classify the access on the bus this cycle.
    always_comb begin
        is_status = !ce_n && !di && wr_n;
        accept    = !ce_n && !is_status && !busy;
        data_acc  = accept && di;
        instr_wr  = accept && !di && !wr_n;
        op        = decode_op(din);
        ld_x      = instr_wr && (op == OP_SET_X) && (int'(din[3:0]) < X_PAGES);
        ld_y      = instr_wr && (op == OP_SET_Y) && (int'(din[6:0]) < Y_LINES);
        ram_addr  = AW'(y_q) * AW'(X_PAGES) + AW'(x_q);
    end

    glcd_phi_sync #(.STAGES(SYNC_STAGES)) i_phi_sync (
        .clk(clk), .rst_n(rst_n), .phi(phi), .rise(phi_rise)
    );

    glcd_busy_timer #(.EDGES(BUSY_EDGES)) i_busy (
        .clk(clk), .rst_n(rst_n), .start(accept), .tick(phi_rise), .busy(busy)
    );

    glcd_wrap_ctr #(.MODULUS(X_PAGES)) i_x_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_x), .load_val(din[XW-1:0]),
        .step(data_acc && !mode_y), .down(mode_down), .q(x_q)
    );

    glcd_wrap_ctr #(.MODULUS(Y_LINES)) i_y_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_y), .load_val(din[YW-1:0]),
        .step(data_acc && mode_y), .down(mode_down), .q(y_q)
    );

    glcd_disp_ram #(.DEPTH(DEPTH), .DW(BYTE_W)) i_ram (
        .clk(clk), .we(data_acc && !wr_n), .re(data_acc && wr_n),
        .addr(ram_addr), .wdata(din), .rdata(ram_q)
    );

    // Control registers written by accepted instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_y     <= 1'b0;
            mode_down  <= 1'b0;
            disp_on    <= 1'b0;
            start_line <= '0;
        end else if (instr_wr) begin
            case (op)
                OP_MODE:  begin mode_y <= din[1]; mode_down <= din[0]; end
                OP_DISP:  disp_on    <= din[0];
                OP_START: start_line <= din[LINE_W-1:0];
                default:  ;
            endcase
        end
    end

    // Capture the status byte and remember which source drives dout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= '0;
            show_status <= 1'b1;
        end else if (is_status) begin
            status_q    <= {busy, 1'b0, disp_on, 5'b0};
            show_status <= 1'b1;
        end else if (data_acc && wr_n) begin
            show_status <= 1'b0;
        end
    end

    assign dout = show_status ? status_q : ram_q;

endmodule

// File: rtl/glcd_host_if_chk.sv
// Module: protocol checker for glcd_host_if, attached by bind. It watches
// the bus, the busy flag, the X counter and the control outputs.
module glcd_host_if_chk #(
    parameter int X_PAGES = 10,
    parameter int XW      = 4,
    parameter int LINE_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              wr_n,
    input logic              di,
    input logic              busy,
    input logic              mode_y,
    input logic              mode_down,
    input logic [XW-1:0]     x_q,
    input logic [7:0]        dout,
    input logic              disp_on,
    input logic [LINE_W-1:0] start_line
);

    // R1: reset clears the outputs and the busy flag.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (dout == 8'h00 && !disp_on && start_line == '0 && !busy));

    // R9: an honoured non-status access raises busy.
    p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !(!di && wr_n) && !busy) |=> busy);

    // R9: busy never lasts a single cycle.
    p_busy_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R8: the status byte reflects the previous cycle's flags.
    p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !di && wr_n) |=>
            dout == {$past(busy), 1'b0, $past(disp_on), 5'b0});

    // R10: nothing changes the control registers while busy.
    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(disp_on) && $stable(start_line)));

    // R3: in X-up mode an honoured data access steps X with wrap.
    p_xstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && di && !busy && !mode_y && !mode_down) |=>
            x_q == (($past(x_q) == XW'(X_PAGES - 1)) ? '0 : $past(x_q) + XW'(1)));

endmodule

bind glcd_host_if glcd_host_if_chk #(
    .X_PAGES(X_PAGES), .XW(XW), .LINE_W(LINE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .di(di),
    .busy(busy), .mode_y(mode_y), .mode_down(mode_down), .x_q(x_q),
    .dout(dout), .disp_on(disp_on), .start_line(start_line)
);

// File: tb/test_glcd_host_if.sv
// Bench: directed scenarios plus a behavioural reference model compared
// against the outputs on every clock.
module test_glcd_host_if;

    localparam int CLK_P    = 10;
    localparam int PHI_HALF = 5;

    logic       clk = 1'b0, rst_n = 1'b0, phi = 1'b0;
    logic       ce_n = 1'b1, wr_n = 1'b1, di = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       disp_on;
    logic [5:0] start_line;

    int tests = 0, fails = 0;
    bit cmp_en = 0, done = 0;

    glcd_host_if i_glcd_host_if (
        .clk(clk), .rst_n(rst_n), .phi(phi), .ce_n(ce_n), .wr_n(wr_n),
        .di(di), .din(din), .dout(dout), .disp_on(disp_on),
        .start_line(start_line)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            repeat (PHI_HALF) @(negedge clk);
            phi = ~phi;
        end
    end

    // ---------------- reference model ----------------
    int  m_x, m_y, m_cnt, m_start, m_dout;
    bit  m_ysel, m_down, m_on, m_busy, m_dk;
    bit  h1, h2, h3;
    int  m_mem [650];
    bit  m_known [650];

    always @(posedge clk) begin
        bit rise, stat;
        int a;
        if (!rst_n) begin
            m_x = 0; m_y = 0; m_cnt = 0; m_start = 0; m_dout = 0;
            m_ysel = 0; m_down = 0; m_on = 0; m_busy = 0; m_dk = 1;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            rise = h2 && !h3;
            stat = !ce_n && !di && wr_n;
            if (stat) begin
                m_dout = {m_busy, 1'b0, m_on, 5'b0};
                m_dk = 1;
            end
            if (!ce_n && !stat && !m_busy) begin
                if (di) begin
                    a = m_y * 10 + m_x;
                    if (!wr_n) begin m_mem[a] = din; m_known[a] = 1; end
                    else begin m_dout = m_mem[a]; m_dk = m_known[a]; end
                    if (m_ysel) m_y = m_down ? (m_y + 64) % 65 : (m_y + 1) % 65;
                    else        m_x = m_down ? (m_x + 9) % 10 : (m_x + 1) % 10;
                end else begin
                    if (din[7]) begin
                        if (din[6:0] < 65) m_y = din[6:0];
                    end else if (din[6]) m_start = din[5:0];
                    else if (din[5:4] == 2'b10) begin
                        if (din[3:0] < 10) m_x = din[3:0];
                    end else if (din[5:2] == 4'b0100) begin
                        m_ysel = din[1]; m_down = din[0];
                    end else if (din[5:1] == 5'b00001) m_on = din[0];
                end
                m_busy = 1; m_cnt = 0;
            end else if (m_busy && rise) begin
                if (m_cnt == 1) m_busy = 0;
                else m_cnt = m_cnt + 1;
            end
            h3 = h2; h2 = h1; h1 = phi;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R2, R6, R7, R8).
    always @(negedge clk) begin
        if (cmp_en) begin
            if (m_dk) chk("R2/R8 model dout", dout, m_dout);
            chk("R7 model disp_on", disp_on, m_on);
            chk("R6 model start_line", start_line, m_start);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic acc(input bit d, input bit w, input logic [7:0] v);
        @(negedge clk);
        ce_n = 0; di = d; wr_n = w; din = v;
        @(negedge clk);
        ce_n = 1; wr_n = 1; di = 0;
    endtask

    task automatic wait_idle(output int polls);
        polls = 0;
        do begin
            acc(0, 1, 8'h00);
            polls++;
        end while (dout[7] && polls < 100);
    endtask

    task automatic cmd(input logic [7:0] v);
        int p;
        acc(0, 0, v);
        wait_idle(p);
    endtask

    task automatic wr(input logic [7:0] v);
        int p;
        acc(1, 0, v);
        wait_idle(p);
    endtask

    task automatic rd(output logic [7:0] v);
        int p;
        acc(1, 1, 8'h00);
        v = dout;
        wait_idle(p);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] v, d0;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        chk("R1 dout after reset", dout, 8'h00);
        chk("R1 disp_on after reset", disp_on, 0);
        chk("R1 start_line after reset", start_line, 0);
        acc(0, 1, 8'h00);
        chk("R1/R8 status after reset", dout, 8'h00);

        // R7/R8/R9: on, busy visible immediately, then clears in time.
        acc(0, 0, 8'h03);
        acc(0, 1, 8'h00);
        chk("R8/R9 status while busy", dout, 8'hA0);
        wait_idle(p);
        chk("R9 busy window bounded", int'(p <= 13), 1);
        chk("R8 status idle and on", dout, 8'h20);
        chk("R7 display on", disp_on, 1);

        // R6/R10: second start line while busy is ignored.
        acc(0, 0, 8'h45);
        acc(0, 0, 8'h4A);
        wait_idle(p);
        chk("R6/R10 start line kept", start_line, 5);

        // R2/R3: X-up sequential writes.
        cmd(8'h23); cmd(8'h85);
        wr(8'hA1); wr(8'hB2);
        cmd(8'h23);
        rd(v); chk("R2 read first", v, 8'hA1);
        rd(v); chk("R3 X up step", v, 8'hB2);

        // R3: X wraps 9 -> 0.
        cmd(8'h29); cmd(8'h80);
        wr(8'h11); wr(8'h22);
        cmd(8'h20); rd(v); chk("R3 X wrap up", v, 8'h22);
        cmd(8'h29); rd(v); chk("R2 X=9 byte", v, 8'h11);

        // R3/R4: Y down wraps 0 -> 64.
        cmd(8'h13); cmd(8'h22); cmd(8'h80);
        wr(8'h33); wr(8'h44);
        cmd(8'hC0); rd(v); chk("R4 Y down wrap", v, 8'h44);
        cmd(8'h80); rd(v); chk("R3 Y=0 byte", v, 8'h33);

        // R3/R4: X down wraps 0 -> 9.
        cmd(8'h11); cmd(8'h20); cmd(8'h81);
        wr(8'h5A); wr(8'h6B);
        cmd(8'h29); rd(v); chk("R4 X down wrap", v, 8'h6B);

        // R5: out-of-range X load ignored.
        cmd(8'h10); cmd(8'h24); cmd(8'h2C); cmd(8'h82);
        wr(8'h55);
        cmd(8'h24); rd(v); chk("R5 X=12 ignored", v, 8'h55);

        // R5: out-of-range Y load ignored.
        cmd(8'h87); cmd(8'hE4); cmd(8'h25);
        wr(8'h66);
        cmd(8'h87); cmd(8'h25); rd(v); chk("R5 Y=100 ignored", v, 8'h66);

        // R7: display off leaves memory alone.
        cmd(8'h02);
        chk("R7 display off", disp_on, 0);
        cmd(8'h25); rd(v); chk("R7 ram unchanged", v, 8'h66);

        // R10: data accesses while busy are ignored.
        cmd(8'h25);
        d0 = dout;
        acc(0, 0, 8'h25);
        acc(1, 0, 8'h99);
        acc(1, 1, 8'h00);
        chk("R10 dout held while busy", dout, d0);
        wait_idle(p);
        rd(v); chk("R10 write while busy ignored", v, 8'h66);

        // R3/R4: Y up wraps 64 -> 0.
        cmd(8'h12); cmd(8'h23); cmd(8'hC0);
        wr(8'h7E); wr(8'h8F);
        cmd(8'h80); rd(v); chk("R3 Y up wrap", v, 8'h8F);

        // R6: maximum start line.
        cmd(8'h7F);
        chk("R6 start line 63", start_line, 63);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule